// File: doc/BRIEF.md
# Field-Proportional PWM Generator with Calibration Window

This block turns a signed, already filtered magnetic-field sample into one push/pull pulse-width-modulated output. The duty cycle is the high time divided by the carrier period. It is made of a quiescent duty plus the sample scaled by a trimmed sensitivity. The quiescent duty sits near the middle of the range for bipolar use or near the low end for unipolar use. The result is held between fixed lower and upper clamp levels, so a receiver can tell a shorted or open line from a valid reading.

The carrier is a prescaler followed by a step counter with 2^DUTY_W steps per period. A 4-bit frequency trim sets how many clocks each step lasts. New duty and period values are taken only at the boundary between two periods, so no period is ever cut short. An optional calibration window follows reset. For the first CAL_PERIODS carrier periods it forces the quiescent duty, which lets a receiver measure its own threshold error. The window is counted in periods, so it grows longer when the carrier is slowed.

Top module: `fieldpwm_gen`

## Requirements
- R1: Each carrier period lasts FULL*T clocks, where FULL = 2^DUTY_W and T is the step length in clocks. The output is high for the first D*T clocks of the period, where D is the latched duty, so every period begins with a rising edge.
- R2: The step length is T = DIV_BASE + (15 - freq_code_i)*DIV_STEP clocks, with a minimum of 1. A higher code therefore gives a shorter period.
- R3: The latched duty never exceeds HI = floor(FULL*92/100) and never falls below LO = floor(FULL*8/100). This applies in every mode, including during the calibration window.
- R4: With all fine-trim bits zero and a zero sample, the duty is FULL/2 when uni_mode_i = 0 and floor(FULL*10/100) when uni_mode_i = 1.
- R5: In qfine_code_i, bits [7:0] give an offset magnitude. Bit 8 = 0 adds the offset to the quiescent base and bit 8 = 1 subtracts it.
- R6: The field term is floor(sample_i * (SENS_BASE + sens_code_i) / 2^SENS_SHIFT), with sample_i in two's complement. A positive sample raises the duty and a negative sample lowers it.
- R7: The field term is saturated to the range -FULL to +FULL before it is added, so extreme samples land on HI or LO and never wrap.
- R8: Changes to any input during a period have no effect on that period's duty or length. They take effect from the next period.
- R9: While rst is high the output is low, and the calibration period count returns to zero.
- R10: When cal_en_i = 1, the first CAL_PERIODS periods after reset carry the clamped quiescent duty whatever the sample. The window therefore lasts CAL_PERIODS*FULL*T clocks, and the field duty applies from the next period.
- R11: When cal_en_i = 0, the very first period after reset already carries the field-dependent duty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | SAMP_W | Signed filtered field sample |
| sens_code_i | input | 8 | Sensitivity trim code |
| qfine_code_i | input | 9 | Fine quiescent trim: bit 8 is the direction, bits [7:0] the magnitude |
| uni_mode_i | input | 1 | Coarse quiescent select: 1 = unipolar, 0 = bipolar |
| freq_code_i | input | 4 | Carrier frequency trim code |
| cal_en_i | input | 1 | Enables the quiescent window after reset |
| pwm_o | output | 1 | PWM output |

## Verification
The assertions assume that reset is applied before the first clock edge. They also assume that the trim inputs are legal binary values and that the step length evaluates to at least one clock. The bench holds reset high from time zero. It picks frequency codes whose periods fit the cycle budget, and it changes inputs only on falling clock edges. It draws samples over the full signed range, so both saturation directions and the clamps are reached alongside in-range values.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;

    localparam int SENS_W       = 8;
    localparam int QFINE_W      = 9;
    localparam int FREQ_W       = 4;
    localparam int PCT_CLAMP_HI = 92;
    localparam int PCT_CLAMP_LO = 8;
    localparam int PCT_Q_UNI    = 10;

    typedef enum logic [0:0] {
        SRC_FIELD = 1'b0,
        SRC_QUIET = 1'b1
    } fpwm_src_e;

    // Integer share of a full scale, rounded down.
    function automatic int pct_of(input int full, input int pct);
        return (full * pct) / 100;
    endfunction

endpackage

// File: rtl/fpwm_duty_calc.sv
module fpwm_duty_calc
    import fpwm_pkg::*;
#(
    parameter int DUTY_W     = 11,
    parameter int SAMP_W     = 12,
    parameter int SENS_BASE  = 64,
    parameter int SENS_SHIFT = 6
) (
    input  logic signed [SAMP_W-1:0]  sample_i,
    input  logic        [SENS_W-1:0]  sens_i,
    input  logic        [QFINE_W-1:0] qfine_i,
    input  logic                      uni_i,
    output logic        [DUTY_W-1:0]  field_duty_o,
    output logic        [DUTY_W-1:0]  quiet_duty_o
);

    localparam int FULL   = 1 << DUTY_W;
    localparam int HI     = pct_of(FULL, PCT_CLAMP_HI);
    localparam int LO     = pct_of(FULL, PCT_CLAMP_LO);
    localparam int Q_BI   = FULL / 2;
    localparam int Q_UNI  = pct_of(FULL, PCT_Q_UNI);
    localparam int GAIN_W = SENS_W + 2;
    localparam int PROD_W = SAMP_W + GAIN_W + 1;
    localparam int MAG_W  = QFINE_W - 1;
    localparam int AW     = ((DUTY_W > MAG_W) ? DUTY_W : MAG_W) + 3;

    localparam logic signed [PROD_W-1:0] SAT_POS = PROD_W'(FULL);
    localparam logic signed [PROD_W-1:0] SAT_NEG = -PROD_W'(FULL);

    logic        [GAIN_W-1:0] gain;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] scaled;
    logic signed [PROD_W-1:0] sat_fld;
    logic signed [AW-1:0]     fld;
    logic signed [AW-1:0]     base;
    logic signed [AW-1:0]     mag;
    logic signed [AW-1:0]     qraw;
    logic signed [AW-1:0]     sum;

    function automatic logic [DUTY_W-1:0] clamp_duty(input logic signed [AW-1:0] v);
        if (v > AW'(HI))      return DUTY_W'(HI);
        else if (v < AW'(LO)) return DUTY_W'(LO);
        else                  return DUTY_W'(v);
    endfunction

    assign gain   = GAIN_W'(SENS_BASE) + GAIN_W'(sens_i);
    assign prod   = PROD_W'(sample_i) * $signed({1'b0, gain});
    assign scaled = prod >>> SENS_SHIFT;

    // Saturate the field term before it meets the quiescent base.
    always_comb begin
        if (scaled > SAT_POS)      sat_fld = SAT_POS;
        else if (scaled < SAT_NEG) sat_fld = SAT_NEG;
        else                       sat_fld = scaled;
    end

    assign fld  = AW'(sat_fld);
    assign base = uni_i ? AW'(Q_UNI) : AW'(Q_BI);
    assign mag  = AW'({1'b0, qfine_i[MAG_W-1:0]});
    assign qraw = qfine_i[QFINE_W-1] ? (base - mag) : (base + mag);
    assign sum  = qraw + fld;

    assign field_duty_o = clamp_duty(sum);
    assign quiet_duty_o = clamp_duty(qraw);

endmodule

// File: rtl/fpwm_carrier.sv
module fpwm_carrier
    import fpwm_pkg::*;
#(
    parameter int DUTY_W   = 11,
    parameter int DIV_BASE = 122,
    parameter int DIV_STEP = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FREQ_W-1:0] freq_i,
    output logic [DUTY_W-1:0] step_o,
    output logic              start_o
);

    localparam int MAXC    = (1 << FREQ_W) - 1;
    localparam int DIV_MAX = DIV_BASE + MAXC * DIV_STEP;
    localparam int DIV_W   = $clog2(DIV_MAX + 2);

    logic [DIV_W-1:0]  ticks_new;
    logic [DIV_W-1:0]  div_q;
    logic [DIV_W-1:0]  presc_q;
    logic [DUTY_W-1:0] step_q;
    logic              tick;

    always_comb begin
        int t;
        t = DIV_BASE + (MAXC - int'(freq_i)) * DIV_STEP;
        if (t < 1) t = 1;
        ticks_new = DIV_W'(t);
    end

    assign tick    = (presc_q == '0);
    assign start_o = tick && (step_q == '1);
    assign step_o  = step_q;

    // Reset parks the counter on the last step so the first edge opens a period.
    always_ff @(posedge clk) begin
        if (rst) begin
            presc_q <= '0;
            step_q  <= '1;
            div_q   <= DIV_W'(1);
        end else if (tick) begin
            step_q <= step_q + DUTY_W'(1);
            if (start_o) begin
                div_q   <= ticks_new;
                presc_q <= ticks_new - DIV_W'(1);
            end else begin
                presc_q <= div_q - DIV_W'(1);
            end
        end else begin
            presc_q <= presc_q - DIV_W'(1);
        end
    end

endmodule

// File: rtl/fpwm_cal_window.sv
module fpwm_cal_window #(
    parameter int CAL_PERIODS = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic cal_en_i,
    output logic hold_o
);

    localparam int CW = $clog2(CAL_PERIODS + 1);

    logic [CW-1:0] cnt_q;
    logic          open_w;

    assign open_w = (cnt_q < CW'(CAL_PERIODS));
    assign hold_o = cal_en_i && open_w;

    always_ff @(posedge clk) begin
        if (rst)                   cnt_q <= '0;
        else if (start_i && open_w) cnt_q <= cnt_q + CW'(1);
    end

endmodule

// File: rtl/fieldpwm_gen.sv
module fieldpwm_gen
    import fpwm_pkg::*;
#(
    parameter int DUTY_W      = 11,
    parameter int SAMP_W      = 12,
    parameter int SENS_BASE   = 64,
    parameter int SENS_SHIFT  = 6,
    parameter int DIV_BASE    = 122,
    parameter int DIV_STEP    = 4,
    parameter int CAL_PERIODS = 100
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic signed [SAMP_W-1:0]  sample_i,
    input  logic        [SENS_W-1:0]  sens_code_i,
    input  logic        [QFINE_W-1:0] qfine_code_i,
    input  logic                      uni_mode_i,
    input  logic        [FREQ_W-1:0]  freq_code_i,
    input  logic                      cal_en_i,
    output logic                      pwm_o
);

    logic [DUTY_W-1:0] field_duty;
    logic [DUTY_W-1:0] duty_quiet;
    logic [DUTY_W-1:0] duty_next;
    logic [DUTY_W-1:0] duty_q;
    logic [DUTY_W-1:0] step_cnt;
    logic              period_start;
    logic              cal_hold;
    fpwm_src_e         src;

    fpwm_duty_calc #(
        .DUTY_W    (DUTY_W),
        .SAMP_W    (SAMP_W),
        .SENS_BASE (SENS_BASE),
        .SENS_SHIFT(SENS_SHIFT)
    ) u_calc (
        .sample_i    (sample_i),
        .sens_i      (sens_code_i),
        .qfine_i     (qfine_code_i),
        .uni_i       (uni_mode_i),
        .field_duty_o(field_duty),
        .quiet_duty_o(duty_quiet)
    );

    fpwm_carrier #(
        .DUTY_W  (DUTY_W),
        .DIV_BASE(DIV_BASE),
        .DIV_STEP(DIV_STEP)
    ) u_carrier (
        .clk    (clk),
        .rst    (rst),
        .freq_i (freq_code_i),
        .step_o (step_cnt),
        .start_o(period_start)
    );

    fpwm_cal_window #(
        .CAL_PERIODS(CAL_PERIODS)
    ) u_cal (
        .clk     (clk),
        .rst     (rst),
        .start_i (period_start),
        .cal_en_i(cal_en_i),
        .hold_o  (cal_hold)
    );

    assign src       = cal_hold ? SRC_QUIET : SRC_FIELD;
    assign duty_next = (src == SRC_QUIET) ? duty_quiet : field_duty;

    always_ff @(posedge clk) begin
        if (rst)               duty_q <= '0;
        else if (period_start) duty_q <= duty_next;
    end

    assign pwm_o = (step_cnt < duty_q);

endmodule

// File: rtl/fpwm_checker.sv
module fpwm_checker
    import fpwm_pkg::*;
#(
    parameter int DUTY_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              pwm_o,
    input logic              start_i,
    input logic              hold_i,
    input logic [DUTY_W-1:0] duty_q_i,
    input logic [DUTY_W-1:0] quiet_i,
    input logic [DUTY_W-1:0] step_i
);

    localparam int FULL = 1 << DUTY_W;
    localparam int HI   = pct_of(FULL, PCT_CLAMP_HI);
    localparam int LO   = pct_of(FULL, PCT_CLAMP_LO);

    // R9: the edge after a reset cycle leaves the output low
    assert_low_in_reset_R9: assert property (@(posedge clk)
        rst |=> !pwm_o);

    // R3: once loaded, the duty stays within the clamp levels
    assert_duty_in_clamp_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (duty_q_i >= DUTY_W'(LO) && duty_q_i <= DUTY_W'(HI)));

    // R8: the duty changes only at a period boundary
    assert_duty_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> $stable(duty_q_i));

    // R1: a boundary restarts the step count and drives the output high
    assert_period_restart_R1: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (step_i == '0) && pwm_o);

    // R10: a boundary inside the window loads the quiescent duty
    assert_cal_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (start_i && hold_i) |=> (duty_q_i == $past(quiet_i)));

endmodule

bind fieldpwm_gen fpwm_checker #(
    .DUTY_W(DUTY_W)
) u_fpwm_chk (
    .clk     (clk),
    .rst     (rst),
    .pwm_o   (pwm_o),
    .start_i (period_start),
    .hold_i  (cal_hold),
    .duty_q_i(duty_q),
    .quiet_i (duty_quiet),
    .step_i  (step_cnt)
);

// File: tb/fieldpwm_gen_bench.sv
module fieldpwm_gen_bench;

    localparam int DW    = 8;
    localparam int SW    = 12;
    localparam int SB    = 64;
    localparam int SS    = 6;
    localparam int DIVB  = 1;
    localparam int DIVS  = 1;
    localparam int CALP  = 4;
    localparam int FULL  = 1 << DW;
    localparam int HI    = (FULL * 92) / 100;
    localparam int LO    = (FULL * 8) / 100;
    localparam int QBI   = FULL / 2;
    localparam int QUNI  = (FULL * 10) / 100;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic signed [SW-1:0] sample = '0;
    logic [7:0]           sens = '0;
    logic [8:0]           qfine = '0;
    logic                 uni = 1'b0;
    logic [3:0]           freq = 4'd15;
    logic                 cal_en = 1'b0;
    logic                 pwm;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // pending config applied part-way through a period
    int p_s, p_sens, p_qf, p_freq;
    bit p_uni;

    always #5 clk = ~clk;

    fieldpwm_gen #(
        .DUTY_W(DW), .SAMP_W(SW), .SENS_BASE(SB), .SENS_SHIFT(SS),
        .DIV_BASE(DIVB), .DIV_STEP(DIVS), .CAL_PERIODS(CALP)
    ) u_fieldpwm_gen (
        .clk(clk), .rst(rst), .sample_i(sample), .sens_code_i(sens),
        .qfine_code_i(qfine), .uni_mode_i(uni), .freq_code_i(freq),
        .cal_en_i(cal_en), .pwm_o(pwm)
    );

    function automatic int exp_ticks(input int code);
        int t;
        t = DIVB + (15 - code) * DIVS;
        if (t < 1) t = 1;
        return t;
    endfunction

    function automatic int exp_duty(input int s, input int sc, input int qf,
                                    input bit un, input bit quiet);
        int p, base, mag, q, d;
        p = (s * (SB + sc)) >>> SS;
        if (p > FULL)  p = FULL;
        if (p < -FULL) p = -FULL;
        base = un ? QUNI : QBI;
        mag  = qf & 255;
        q    = ((qf & 256) != 0) ? base - mag : base + mag;
        d    = quiet ? q : q + p;
        if (d > HI) d = HI;
        if (d < LO) d = LO;
        return d;
    endfunction

    task automatic chk(input string tag, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic set_cfg(input int s, input int sc, input int qf, input bit un, input int fc);
        sample = SW'(s);
        sens   = 8'(sc);
        qfine  = 9'(qf);
        uni    = un;
        freq   = 4'(fc);
    endtask

    task automatic wait_rise();
        bit prev;
        prev = pwm;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (pwm && !prev) return;
            prev = pwm;
        end
        chk("watchdog rise", 0, 1);
    endtask

    // Entered on the sample that saw a rising edge; leaves on the next one.
    task automatic measure(input int chg_at, output int hi, output int tot);
        bit prev;
        hi = 1; tot = 1; prev = 1'b1;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (pwm && !prev) return;
            prev = pwm;
            tot++;
            if (pwm) hi++;
            if (tot == chg_at) set_cfg(p_s, p_sens, p_qf, p_uni, p_freq);
        end
        chk("watchdog measure", 0, 1);
    endtask

    task automatic do_reset(input bit cal);
        @(negedge clk);
        rst = 1'b1;
        cal_en = cal;
        repeat (4) @(negedge clk);
        chk("R9 output low in reset", int'(pwm), 0);
        rst = 1'b0;
    endtask

    task automatic run_one(input string tag, input int s, input int sc, input int qf,
                           input bit un, input int fc);
        int hi, tot, t, d;
        set_cfg(s, sc, qf, un, fc);
        wait_rise();
        measure(-1, hi, tot);
        t = exp_ticks(fc);
        d = exp_duty(s, sc, qf, un, 1'b0);
        chk({tag, " high"}, hi, d * t);
        chk({tag, " period R1"}, tot, FULL * t);
    endtask

    task automatic cal_run(input int fc);
        int hi, tot, win, t;
        set_cfg(2000, 0, 0, 1'b0, fc);
        do_reset(1'b1);
        wait_rise();
        t = exp_ticks(fc);
        win = 0;
        for (int k = 0; k < CALP; k++) begin
            measure(-1, hi, tot);
            win += tot;
            chk("R10 window quiescent duty", hi, QBI * t);
        end
        chk("R10 window length scales with period", win, CALP * FULL * t);
        measure(-1, hi, tot);
        chk("R7 R10 field duty after window", hi, HI * t);
    endtask

    initial begin
        #(1900000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!done) $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        int hi, tot;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk("R9 output low from power-up", int'(pwm), 0);

        // calibration window at two carrier rates
        cal_run(15);
        cal_run(13);

        // no window: first period already follows the field (R11)
        set_cfg(-2000, 0, 0, 1'b0, 15);
        do_reset(1'b0);
        wait_rise();
        measure(-1, hi, tot);
        chk("R11 R7 first period low clamp", hi, LO * 1);

        // directed corners
        run_one("R4 bipolar quiescent", 0, 0, 0, 1'b0, 15);
        run_one("R4 unipolar quiescent", 0, 0, 0, 1'b1, 15);
        run_one("R5 fine trim down", 0, 0, 9'h10A, 1'b0, 15);
        run_one("R5 fine trim up", 0, 0, 9'h00A, 1'b0, 15);
        run_one("R3 R5 unipolar trimmed under low clamp", 0, 0, 256 + 20, 1'b1, 15);
        run_one("R6 positive field", 100, 0, 0, 1'b0, 15);
        run_one("R6 negative field floor", -20, 100, 0, 1'b0, 15);
        run_one("R7 full negative sample", -2048, 255, 0, 1'b0, 14);
        run_one("R2 code 12", 10, 10, 0, 1'b0, 12);
        run_one("R2 code 0", 0, 0, 0, 1'b0, 0);

        // R8: change everything mid-period
        set_cfg(0, 0, 0, 1'b0, 15);
        wait_rise();
        p_s = 60; p_sens = 0; p_qf = 0; p_uni = 1'b0; p_freq = 14;
        measure(50, hi, tot);
        chk("R8 current period keeps duty", hi, QBI);
        chk("R8 current period keeps length", tot, FULL);
        measure(-1, hi, tot);
        chk("R8 next period new duty", hi, (QBI + 60) * 2);
        chk("R8 next period new length", tot, FULL * 2);

        // constrained random
        for (int k = 0; k < 30; k++) begin
            int s, sc, qf, fc;
            bit un;
            s  = int'($urandom_range(4095)) - 2048;
            sc = int'($urandom_range(255));
            qf = int'($urandom_range(511));
            un = 1'($urandom_range(1));
            fc = int'($urandom_range(15, 12));
            run_one("R3 R6 random", s, sc, qf, un, fc);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule